// File: doc/BRIEF.md
# Flag-Setting Integer ALU

This block is the integer execute stage of a small RISC core that uses 16-bit instructions. It takes two register operands and an 8-bit immediate, and one shared status bit T serves as its carry, borrow, overflow and test flag. A decoded operation select picks one of fifteen register operations or the test-and-set helper. The ALU returns the value to be written back to the destination register and the next value of T. Both outputs are combinational.

T is held in a single flop inside the block. It loads the computed next value only on cycles where the instruction-valid strobe is high. Each operation has its own rule for T. The subtract-with-borrow and negate-with-borrow forms read the current T as a borrow-in and write the borrow-out back. Subtract-with-overflow reports two's-complement overflow. The two test forms report a zero AND result. Operations that define no flag rule leave T untouched. A separate byte path supports test-and-set: it marks the fetched byte by forcing its top bit high and reports whether that byte was zero.

The register file, instruction fetch and the memory access of read-modify-write instructions sit outside this block. For the register-with-immediate forms, the register operand arrives on the first operand port.

Top module: `tflag_alu`

## Requirements
- R1: While `rst` is high at a rising edge, `t_o` becomes 0 one edge later, whatever `valid_i` and the operation are.
- R2: `t_o` takes the value `t_next_o` had at a rising edge where `valid_i` was 1. At an edge where `valid_i` was 0, `t_o` keeps its value.
- R3: Subtract with borrow (`op_i`=3): first tmp = rn − T, then result = tmp − rm. `t_next_o` is 1 when either step wraps as an unsigned value, which is the borrow of rn − rm − T.
- R4: Negate with borrow (`op_i`=1): first tmp = 0 − T, then result = tmp − rm. `t_next_o` is 1 when tmp is nonzero or when the result is unsigned-greater than tmp.
- R5: Subtract with overflow (`op_i`=4): result = rn − rm. `t_next_o` is bit 31 of (rn ^ rm) & (result ^ rn), which is 1 exactly on signed overflow.
- R6: The plain operations give these results. Negate (`op_i`=0) gives −rm. Subtract (2) gives rn − rm. NOT (5) gives ~rm. AND (6) gives rn & rm. OR (7) gives rn | rm. XOR (8) gives rn ^ rm. OR-immediate (14) gives rn | {24'b0, imm}.
- R7: For `op_i` values 0, 2, 5, 6, 7, 8, 9, 10, 11 and 14, `t_next_o` equals the current `t_o`.
- R8: Byte swap (`op_i`=9) keeps rm[31:16] and swaps rm[15:8] with rm[7:0]. Half swap (`op_i`=10) gives {rm[15:0], rm[31:16]}.
- R9: Extract (`op_i`=11) gives {rm[15:0], rn[31:16]}.
- R10: Register test (`op_i`=12) sets `t_next_o` = ((rn & rm) == 0). Immediate test (`op_i`=13) sets `t_next_o` = ((rn & zero-extended imm) == 0). Both tests, and test-and-set, return rn unchanged on `result_o`.
- R11: `tas_byte_o` is `tas_byte_i` with bit 7 forced to 1. `tas_t_o` is 1 exactly when `tas_byte_i` is zero. With `op_i`=15, `t_next_o` equals `tas_t_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| valid_i | input | 1 | Instruction valid; T loads only when high |
| op_i | input | 4 | Decoded operation select |
| rn_i | input | 32 | Destination register operand (R0 for immediate forms) |
| rm_i | input | 32 | Source register operand |
| imm_i | input | 8 | Immediate, zero-extended where used |
| tas_byte_i | input | 8 | Byte fetched by a test-and-set access |
| result_o | output | 32 | Value for the destination register |
| t_next_o | output | 1 | Next value of T for this operation |
| t_o | output | 1 | Current registered T |
| tas_byte_o | output | 8 | Byte to write back for test-and-set |
| tas_t_o | output | 1 | Test-and-set zero flag |

## Verification
The bench drives the borrow chains at their wrap points. One case is rn = 0 with T = 1, which wraps in the first step only. Another is negate-with-borrow of zero with and without a borrow-in. A design that checks only one of the two wrap steps, or treats T as a carry instead of a borrow, gives the wrong flag there. Overflow is probed at the most-negative value minus one; a design that takes the carry instead of the signed overflow would miss it. Instructions with `valid_i` low are mixed into the stream, and T must survive them. The swap and extract results use distinct byte patterns, so a swapped lane or a wrong half is visible.

// File: rtl/tflag_alu_pkg.sv
package tflag_alu_pkg;
   localparam int OP_W   = 4;
   localparam int BYTE_W = 8;

   typedef enum logic [OP_W-1:0] {
      OP_NEG   = 4'd0,
      OP_NEGC  = 4'd1,
      OP_SUB   = 4'd2,
      OP_SUBC  = 4'd3,
      OP_SUBV  = 4'd4,
      OP_NOT   = 4'd5,
      OP_AND   = 4'd6,
      OP_OR    = 4'd7,
      OP_XOR   = 4'd8,
      OP_SWAPB = 4'd9,
      OP_SWAPW = 4'd10,
      OP_XTRCT = 4'd11,
      OP_TST   = 4'd12,
      OP_TSTI  = 4'd13,
      OP_ORI   = 4'd14,
      OP_TAS   = 4'd15
   } op_e;
endpackage

// File: rtl/tfa_sub_unit.sv
module tfa_sub_unit
   import tflag_alu_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  op_e               op,
   input  logic [DATA_W-1:0] rn,
   input  logic [DATA_W-1:0] rm,
   input  logic              t_in,
   output logic [DATA_W-1:0] res,
   output logic              t_out
);
   localparam int MSB = DATA_W - 1;

   logic [DATA_W-1:0] t_ext;
   logic [DATA_W-1:0] tmp;

   assign t_ext = {{(DATA_W-1){1'b0}}, t_in};

   always_comb begin
      tmp   = '0;
      res   = rn;
      t_out = t_in;
      unique case (op)
         OP_NEG: res = '0 - rm;
         OP_SUB: res = rn - rm;
         OP_SUBC: begin
            tmp   = rn - t_ext;
            res   = tmp - rm;
            t_out = (tmp > rn) | (res > tmp);
         end
         OP_NEGC: begin
            tmp   = '0 - t_ext;
            res   = tmp - rm;
            t_out = (tmp != '0) | (res > tmp);
         end
         OP_SUBV: begin
            res   = rn - rm;
            t_out = (rn[MSB] ^ rm[MSB]) & (res[MSB] ^ rn[MSB]);
         end
         default: begin
            res   = rn;
            t_out = t_in;
         end
      endcase
   end
endmodule

// File: rtl/tfa_perm_unit.sv
module tfa_perm_unit
   import tflag_alu_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  op_e               op,
   input  logic [DATA_W-1:0] rn,
   input  logic [DATA_W-1:0] rm,
   output logic [DATA_W-1:0] res
);
   localparam int HALF = DATA_W / 2;

   logic [DATA_W-1:0] swap_h;
   logic [DATA_W-1:0] swap_b;
   logic [DATA_W-1:0] extr;

   for (genvar i = 0; i < HALF; i++) begin : g_half
      assign swap_h[i]      = rm[i+HALF];
      assign swap_h[i+HALF] = rm[i];
   end

   for (genvar k = 0; k < BYTE_W; k++) begin : g_lane
      assign swap_b[k]        = rm[k+BYTE_W];
      assign swap_b[k+BYTE_W] = rm[k];
   end
   assign swap_b[DATA_W-1:2*BYTE_W] = rm[DATA_W-1:2*BYTE_W];

   assign extr = {rm[HALF-1:0], rn[DATA_W-1:HALF]};

   always_comb begin
      unique case (op)
         OP_SWAPB: res = swap_b;
         OP_SWAPW: res = swap_h;
         OP_XTRCT: res = extr;
         default:  res = rn;
      endcase
   end
endmodule

// File: rtl/tfa_logic_unit.sv
module tfa_logic_unit
   import tflag_alu_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int IMM_W  = 8
) (
   input  op_e               op,
   input  logic [DATA_W-1:0] rn,
   input  logic [DATA_W-1:0] rm,
   input  logic [IMM_W-1:0]  imm,
   input  logic              t_in,
   output logic [DATA_W-1:0] res,
   output logic              t_out
);
   logic [DATA_W-1:0] imm_z;

   assign imm_z = {{(DATA_W-IMM_W){1'b0}}, imm};

   always_comb begin
      res   = rn;
      t_out = t_in;
      unique case (op)
         OP_NOT:  res = ~rm;
         OP_AND:  res = rn & rm;
         OP_OR:   res = rn | rm;
         OP_XOR:  res = rn ^ rm;
         OP_ORI:  res = rn | imm_z;
         OP_TST:  t_out = ((rn & rm) == '0);
         OP_TSTI: t_out = ((rn & imm_z) == '0);
         default: begin
            res   = rn;
            t_out = t_in;
         end
      endcase
   end
endmodule

// File: rtl/tfa_tas_unit.sv
module tfa_tas_unit
   import tflag_alu_pkg::*;
(
   input  logic [BYTE_W-1:0] byte_in,
   output logic [BYTE_W-1:0] byte_out,
   output logic              zero
);
   assign byte_out = {1'b1, byte_in[BYTE_W-2:0]};
   assign zero     = (byte_in == '0);
endmodule

// File: rtl/tflag_alu.sv
module tflag_alu
   import tflag_alu_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int IMM_W  = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              valid_i,
   input  logic [OP_W-1:0]   op_i,
   input  logic [DATA_W-1:0] rn_i,
   input  logic [DATA_W-1:0] rm_i,
   input  logic [IMM_W-1:0]  imm_i,
   input  logic [BYTE_W-1:0] tas_byte_i,
   output logic [DATA_W-1:0] result_o,
   output logic              t_next_o,
   output logic              t_o,
   output logic [BYTE_W-1:0] tas_byte_o,
   output logic              tas_t_o
);
   if (DATA_W < 32 || (DATA_W % 16) != 0) begin : g_bad_width
      $error("tflag_alu: DATA_W must be a multiple of 16 and at least 32");
   end
   if (IMM_W < 1 || IMM_W >= DATA_W) begin : g_bad_imm
      $error("tflag_alu: IMM_W must lie between 1 and DATA_W-1");
   end

   op_e               op_s;
   logic [DATA_W-1:0] sub_res, perm_res, logic_res;
   logic              sub_t, logic_t, tas_zero;
   logic              t_q;

   assign op_s = op_e'(op_i);

   tfa_sub_unit #(.DATA_W(DATA_W)) u_sub (
      .op(op_s), .rn(rn_i), .rm(rm_i), .t_in(t_q),
      .res(sub_res), .t_out(sub_t)
   );

   tfa_perm_unit #(.DATA_W(DATA_W)) u_perm (
      .op(op_s), .rn(rn_i), .rm(rm_i), .res(perm_res)
   );

   tfa_logic_unit #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_logic (
      .op(op_s), .rn(rn_i), .rm(rm_i), .imm(imm_i), .t_in(t_q),
      .res(logic_res), .t_out(logic_t)
   );

   tfa_tas_unit u_tas (
      .byte_in(tas_byte_i), .byte_out(tas_byte_o), .zero(tas_zero)
   );

   always_comb begin
      unique case (op_s)
         OP_NEG, OP_NEGC, OP_SUB, OP_SUBC, OP_SUBV: begin
            result_o = sub_res;
            t_next_o = sub_t;
         end
         OP_SWAPB, OP_SWAPW, OP_XTRCT: begin
            result_o = perm_res;
            t_next_o = t_q;
         end
         OP_TAS: begin
            result_o = rn_i;
            t_next_o = tas_zero;
         end
         default: begin
            result_o = logic_res;
            t_next_o = logic_t;
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst)          t_q <= 1'b0;
      else if (valid_i) t_q <= t_next_o;
   end

   assign t_o     = t_q;
   assign tas_t_o = tas_zero;
endmodule

// File: rtl/tflag_alu_chk.sv
module tflag_alu_chk
   import tflag_alu_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst,
   input logic              valid_i,
   input logic [OP_W-1:0]   op_i,
   input logic [DATA_W-1:0] rn_i,
   input logic [DATA_W-1:0] rm_i,
   input logic [DATA_W-1:0] result_o,
   input logic              t_next_o,
   input logic              t_o,
   input logic [BYTE_W-1:0] tas_byte_o,
   input logic              tas_t_o
);
   localparam int MSB = DATA_W - 1;

   AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> !t_o); // R1

   AST_T_HOLD: assert property (@(posedge clk) disable iff (rst)
      !valid_i |=> $stable(t_o)); // R2

   AST_T_LOAD: assert property (@(posedge clk) disable iff (rst)
      valid_i |=> (t_o == $past(t_next_o))); // R2

   AST_SUBV_FLAG: assert property (@(posedge clk) disable iff (rst)
      (op_i == OP_SUBV) |->
         (t_next_o == ((rn_i[MSB] != rm_i[MSB]) && (result_o[MSB] != rn_i[MSB])))); // R5

   AST_T_PASS: assert property (@(posedge clk) disable iff (rst)
      (op_i inside {OP_NEG, OP_SUB, OP_NOT, OP_AND, OP_OR, OP_XOR,
                    OP_SWAPB, OP_SWAPW, OP_XTRCT, OP_ORI}) |-> (t_next_o == t_o)); // R7

   AST_TEST_KEEP: assert property (@(posedge clk) disable iff (rst)
      (op_i inside {OP_TST, OP_TSTI, OP_TAS}) |-> (result_o == rn_i)); // R10

   AST_TAS_ZERO: assert property (@(posedge clk) disable iff (rst)
      tas_t_o |-> (tas_byte_o == 8'h80)); // R11

   AST_TAS_FLAG: assert property (@(posedge clk) disable iff (rst)
      (op_i == OP_TAS) |-> (t_next_o == tas_t_o)); // R11
endmodule

bind tflag_alu tflag_alu_chk #(.DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst(rst), .valid_i(valid_i), .op_i(op_i),
   .rn_i(rn_i), .rm_i(rm_i), .result_o(result_o), .t_next_o(t_next_o),
   .t_o(t_o), .tas_byte_o(tas_byte_o), .tas_t_o(tas_t_o)
);

// File: tb/tflag_alu_tb_top.sv
module tflag_alu_tb_top;
   import tflag_alu_pkg::*;

   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        valid_i = 1'b0;
   logic [3:0]  op_i = 4'd0;
   logic [31:0] rn_i = '0, rm_i = '0;
   logic [7:0]  imm_i = '0, tas_byte_i = '0;
   logic [31:0] result_o;
   logic        t_next_o, t_o, tas_t_o;
   logic [7:0]  tas_byte_o;

   int n_tests = 0;
   int n_fail  = 0;
   logic t_model = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   tflag_alu dut_i (
      .clk(clk), .rst(rst), .valid_i(valid_i), .op_i(op_i),
      .rn_i(rn_i), .rm_i(rm_i), .imm_i(imm_i), .tas_byte_i(tas_byte_i),
      .result_o(result_o), .t_next_o(t_next_o), .t_o(t_o),
      .tas_byte_o(tas_byte_o), .tas_t_o(tas_t_o)
   );

   function automatic string req_of(logic [3:0] op);
      case (op)
         OP_SUBC: return "R3";
         OP_NEGC: return "R4";
         OP_SUBV: return "R5";
         OP_SWAPB, OP_SWAPW: return "R8";
         OP_XTRCT: return "R9";
         OP_TST, OP_TSTI: return "R10";
         OP_TAS: return "R11";
         default: return "R6";
      endcase
   endfunction

   // returns {next T, result}
   function automatic logic [32:0] model(logic [3:0] op, logic [31:0] rn, logic [31:0] rm,
                                         logic [7:0] imm, logic [7:0] tb, logic t);
      logic [32:0] d;
      logic [31:0] r;
      logic        nt;
      r  = rn;
      nt = t;
      case (op)
         OP_NEG:  r = 32'd0 - rm;
         OP_NEGC: begin d = 33'd0 - {1'b0, rm} - {32'd0, t}; r = d[31:0]; nt = d[32]; end
         OP_SUB:  r = rn - rm;
         OP_SUBC: begin d = {1'b0, rn} - {1'b0, rm} - {32'd0, t}; r = d[31:0]; nt = d[32]; end
         OP_SUBV: begin
            d  = {rn[31], rn} - {rm[31], rm};
            r  = d[31:0];
            nt = d[32] != d[31];
         end
         OP_NOT:   r = ~rm;
         OP_AND:   r = rn & rm;
         OP_OR:    r = rn | rm;
         OP_XOR:   r = rn ^ rm;
         OP_ORI:   r = rn | {24'd0, imm};
         OP_SWAPB: r = {rm[31:16], rm[7:0], rm[15:8]};
         OP_SWAPW: r = {rm[15:0], rm[31:16]};
         OP_XTRCT: r = {rm[15:0], rn[31:16]};
         OP_TST:   nt = ((rn & rm) == 32'd0);
         OP_TSTI:  nt = ((rn[7:0] & imm) == 8'd0);
         OP_TAS:   nt = (tb == 8'd0);
         default:  r = rn;
      endcase
      return {nt, r};
   endfunction

   task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // called at a negedge; returns at the next negedge
   task automatic apply(logic [3:0] op, logic [31:0] rn, logic [31:0] rm,
                        logic [7:0] imm, logic [7:0] tb, logic v);
      logic [32:0] e;
      op_i = op; rn_i = rn; rm_i = rm; imm_i = imm; tas_byte_i = tb; valid_i = v;
      #1;
      e = model(op, rn, rm, imm, tb, t_model);
      check(req_of(op), "result", result_o, e[31:0]);
      if (op inside {OP_NEG, OP_SUB, OP_NOT, OP_AND, OP_OR, OP_XOR, OP_ORI,
                     OP_SWAPB, OP_SWAPW, OP_XTRCT})
         check("R7", "t_next", {31'd0, t_next_o}, {31'd0, e[32]});
      else
         check(req_of(op), "t_next", {31'd0, t_next_o}, {31'd0, e[32]});
      check("R11", "tas_byte", {24'd0, tas_byte_o}, {24'd0, tb | 8'h80});
      check("R11", "tas_t", {31'd0, tas_t_o}, {31'd0, tb == 8'd0});
      @(negedge clk);
      if (v) t_model = e[32];
      check("R2", "t_o", {31'd0, t_o}, {31'd0, t_model});
   endtask

   initial begin
      #(CLK_P * 150000);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_1234));
      @(negedge clk);
      // R1: valid immediate test that would set T is issued during reset
      op_i = OP_TSTI; imm_i = 8'd0; valid_i = 1'b1;
      repeat (3) @(negedge clk);
      check("R1", "t_o in reset", {31'd0, t_o}, 32'd0);
      rst = 1'b0;

      // directed corners
      apply(OP_TSTI, 32'h0000_00ff, 32'd0, 8'h00, 8'h11, 1'b1);          // R10 T=1
      apply(OP_SUBC, 32'd0, 32'd0, 8'd0, 8'h11, 1'b1);                   // R3 first step wraps
      apply(OP_SUBC, 32'd5, 32'd5, 8'd0, 8'h11, 1'b1);                   // R3 second step
      apply(OP_TST,  32'd1, 32'd1, 8'd0, 8'h11, 1'b1);                   // R10 T=0
      apply(OP_SUBC, 32'd5, 32'd3, 8'd0, 8'h11, 1'b1);                   // R3 no borrow
      apply(OP_NEGC, 32'd0, 32'd0, 8'd0, 8'h11, 1'b1);                   // R4 zero, no borrow
      apply(OP_TSTI, 32'd0, 32'd0, 8'h3c, 8'h11, 1'b1);                  // T=1
      apply(OP_NEGC, 32'd0, 32'd0, 8'd0, 8'h11, 1'b1);                   // R4 zero, borrow in
      apply(OP_SUBV, 32'h8000_0000, 32'd1, 8'd0, 8'h11, 1'b1);           // R5 overflow
      apply(OP_SUBV, 32'd5, 32'd3, 8'd0, 8'h11, 1'b1);                   // R5 none
      apply(OP_SUBC, 32'd0, 32'd1, 8'd0, 8'h11, 1'b0);                   // R2 held when invalid
      apply(OP_SWAPB, 32'd0, 32'h1234_5678, 8'd0, 8'h11, 1'b1);          // R8
      apply(OP_SWAPW, 32'd0, 32'h1234_5678, 8'd0, 8'h11, 1'b1);          // R8
      apply(OP_XTRCT, 32'haabb_ccdd, 32'h1122_3344, 8'd0, 8'h11, 1'b1);  // R9
      apply(OP_ORI, 32'h0000_1200, 32'd0, 8'h34, 8'h11, 1'b1);           // R6
      apply(OP_TAS, 32'h0000_0042, 32'd0, 8'd0, 8'h00, 1'b1);            // R11 zero byte
      apply(OP_TAS, 32'h0000_0042, 32'd0, 8'd0, 8'h05, 1'b1);            // R11 nonzero byte
      apply(OP_NEG, 32'd0, 32'd7, 8'd0, 8'h11, 1'b1);                    // R6, R7

      // constrained random
      for (int i = 0; i < 600; i++) begin
         logic [31:0] a, b;
         logic [3:0]  o;
         a = $urandom();
         b = $urandom();
         o = 4'($urandom_range(0, 15));
         case ($urandom_range(0, 5))
            0: b = a;
            1: b = 32'd0;
            2: a = ~b;
            default: ;
         endcase
         apply(o, a, b, 8'($urandom()), ($urandom_range(0, 3) == 0) ? 8'd0 : 8'($urandom()),
               ($urandom_range(0, 3) != 0));
      end

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule